// File: doc/BRIEF.md
# Two-Cycle Ternary Bit-Manipulation Unit

This unit evaluates six 32-bit bit-manipulation operations that each take exactly two clock cycles: conditional mix, conditional move, rotate left, rotate right, funnel shift left and funnel shift right. A request carries an operation code and three source operands. The cycle in which the unit accepts it is the first cycle. The result appears in the second cycle. A single stage register carries the partial value from the first cycle into the second.

Requests use a valid/ready handshake. The unit takes a request when `in_valid_i` and `in_ready_o` are both high. In that same cycle `busy_o` rises, and the upstream pipeline must stall and keep the sources on the inputs for one more cycle. During the second cycle `in_ready_o` is low and any request shown is not taken. The output side has no back-pressure. `out_valid_o` is a single-cycle pulse, and the consumer must take `result_o` in that cycle.

Internally, a one-bit flag register marks the second cycle of a three-operand operation. This flag steers the first datapath input from `src1_i` to `src3_i`. It is a short path, not a decode of the operation code.

Top module: `tbm_unit`

## Requirements
- R1: After reset `in_ready_o` is 1 and `out_valid_o` and `busy_o` are 0. `busy_o` is high exactly in a cycle where `in_valid_i` and `in_ready_o` are both high.
- R2: `out_valid_o` is high for exactly one cycle, the cycle right after acceptance. In that cycle `in_ready_o` and `busy_o` are 0.
- R3: A request shown while `in_ready_o` is 0 is not taken: the next cycle has `out_valid_o` 0 and `in_ready_o` 1. A change of `op_i` during the second cycle does not alter the result, because the code is latched at acceptance.
- R4: For the three-operand codes (0, 1, 4, 5), the second cycle no longer reads `src1_i`. A change of `src1_i` in that cycle leaves the result unchanged.
- R5: Code 0, conditional mix, gives (src1 & src2) | (src3 & ~src2).
- R6: Code 1, conditional move, gives src1 when src2 is nonzero and src3 when src2 is zero.
- R7: Code 2 rotates src1 left, and code 3 rotates it right. The amount is src2[4:0] in both cases.
- R8: The funnel codes use the amount k = src2[5:0]. With A = src1 and B = src3, if k >= 32 then A and B swap and s = k - 32; otherwise s = k. Code 5, funnel right, gives the low word of {B,A} >> s. Code 4, funnel left, gives the high word of {A,B} << s.
- R9: For both funnel codes, k = 0 gives src1 and k = 32 gives src3.
- R10: The reserved codes 6 and 7 complete in two cycles with a result of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Request present |
| in_ready_o | output | 1 | Unit can take a request this cycle |
| op_i | input | 3 | Operation code |
| src1_i | input | 32 | First source operand |
| src2_i | input | 32 | Second source operand (control mask, condition or amount) |
| src3_i | input | 32 | Third source operand |
| busy_o | output | 1 | Stall request, high in the acceptance cycle |
| out_valid_o | output | 1 | Result valid, one-cycle pulse |
| result_o | output | 32 | Result, zero when `out_valid_o` is low |

## Verification
The bench builds the unit with its default width of 32. This makes the 5-bit rotate amount and the 6-bit funnel amount both reachable by random operands. The directed amounts 0, 31, 32, 33 and 63 hit both sides of the bit-5 operand swap and the two special funnel results. Because the width is a power of two, the complement W - s always fits in the amount field plus one bit. That range includes the shift by the full width, which must give zero.

// File: rtl/tbm_pkg.sv
package tbm_pkg;
  typedef enum logic [2:0] {
    OP_CMIX = 3'd0,
    OP_CMOV = 3'd1,
    OP_ROL  = 3'd2,
    OP_ROR  = 3'd3,
    OP_FSL  = 3'd4,
    OP_FSR  = 3'd5,
    OP_RSV6 = 3'd6,
    OP_RSV7 = 3'd7
  } tbm_op_e;

  function automatic logic is_ternary(tbm_op_e op);
    return (op == OP_CMIX) || (op == OP_CMOV) || (op == OP_FSL) || (op == OP_FSR);
  endfunction
endpackage

// File: rtl/tbm_seq.sv
module tbm_seq
  import tbm_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    in_valid_i,
  input  tbm_op_e op_i,
  output logic    in_ready_o,
  output logic    busy_o,
  output logic    second_o,
  output logic    use_src3_o,
  output tbm_op_e op_q_o
);
  logic    second_q, use_src3_q, accept;
  tbm_op_e op_q;

  assign in_ready_o = ~second_q;
  assign accept     = in_valid_i & ~second_q;
  assign busy_o     = accept;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      second_q   <= 1'b0;
      use_src3_q <= 1'b0;
      op_q       <= OP_CMIX;
    end else begin
      second_q   <= accept;
      use_src3_q <= accept & is_ternary(op_i);
      if (accept) op_q <= op_i;
    end
  end

  assign second_o   = second_q;
  assign use_src3_o = use_src3_q;
  assign op_q_o     = op_q;

  assert_pulse_once_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    second_q |=> !second_q);
  assert_src3_in_second_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    use_src3_q |-> (second_q && is_ternary(op_q)));
  assert_op_kept_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    second_q |=> $stable(op_q) || $past(!second_q));
endmodule

// File: rtl/tbm_first.sv
module tbm_first
  import tbm_pkg::*;
#(
  parameter int W = 32
) (
  input  tbm_op_e        op_i,
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  output logic [W-1:0]   part_o
);
  localparam int SW = $clog2(W);
  localparam int FW = SW + 1;

  logic [SW-1:0] s;
  logic [FW-1:0] sc;
  logic          hi;

  always_comb begin
    s  = b_i[SW-1:0];
    hi = b_i[SW];
    sc = FW'(W) - {1'b0, s};
    unique case (op_i)
      OP_CMIX: part_o = a_i & b_i;
      OP_CMOV: part_o = a_i;
      OP_ROL:  part_o = a_i << s;
      OP_ROR:  part_o = a_i >> s;
      OP_FSL:  part_o = hi ? (a_i >> sc) : (a_i << s);
      OP_FSR:  part_o = hi ? (a_i << sc) : (a_i >> s);
      default: part_o = '0;
    endcase
  end
endmodule

// File: rtl/tbm_second.sv
module tbm_second
  import tbm_pkg::*;
#(
  parameter int W = 32
) (
  input  tbm_op_e        op_i,
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  input  logic [W-1:0]   stage_i,
  output logic [W-1:0]   res_o
);
  localparam int SW = $clog2(W);
  localparam int FW = SW + 1;

  logic [SW-1:0] s;
  logic [FW-1:0] sc;
  logic          hi;

  always_comb begin
    s  = b_i[SW-1:0];
    hi = b_i[SW];
    sc = FW'(W) - {1'b0, s};
    unique case (op_i)
      OP_CMIX: res_o = stage_i | (a_i & ~b_i);
      OP_CMOV: res_o = (|b_i) ? stage_i : a_i;
      OP_ROL:  res_o = stage_i | (a_i >> sc[SW-1:0]);
      OP_ROR:  res_o = stage_i | (a_i << sc[SW-1:0]);
      OP_FSL:  res_o = stage_i | (hi ? (a_i << s) : (a_i >> sc));
      OP_FSR:  res_o = stage_i | (hi ? (a_i >> s) : (a_i << sc));
      default: res_o = '0;
    endcase
  end
endmodule

// File: rtl/tbm_unit.sv
module tbm_unit
  import tbm_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         in_valid_i,
  output logic         in_ready_o,
  input  logic [2:0]   op_i,
  input  logic [W-1:0] src1_i,
  input  logic [W-1:0] src2_i,
  input  logic [W-1:0] src3_i,
  output logic         busy_o,
  output logic         out_valid_o,
  output logic [W-1:0] result_o
);
  logic         second, use_src3;
  tbm_op_e      op_q, op_in;
  logic [W-1:0] opnd_a, part, stage_q, res;

  assign op_in = tbm_op_e'(op_i);

  tbm_seq u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .in_valid_i (in_valid_i),
    .op_i       (op_in),
    .in_ready_o (in_ready_o),
    .busy_o     (busy_o),
    .second_o   (second),
    .use_src3_o (use_src3),
    .op_q_o     (op_q)
  );

  assign opnd_a = use_src3 ? src3_i : src1_i;

  tbm_first #(.W(W)) u_first (
    .op_i   (op_in),
    .a_i    (opnd_a),
    .b_i    (src2_i),
    .part_o (part)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     stage_q <= '0;
    else if (busy_o) stage_q <= part;
  end

  tbm_second #(.W(W)) u_second (
    .op_i    (op_q),
    .a_i     (opnd_a),
    .b_i     (src2_i),
    .stage_i (stage_q),
    .res_o   (res)
  );

  assign out_valid_o = second;
  assign result_o    = second ? res : '0;

  assert_busy_leads_done_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> out_valid_o);
  assert_done_follows_req_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> $past(in_valid_i));
  assert_cmov_keeps_src1_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && op_q == OP_CMOV && src2_i != '0) |-> (result_o == $past(src1_i)));
  assert_reserved_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && (op_q == OP_RSV6 || op_q == OP_RSV7)) |-> (result_o == '0));
endmodule

// File: tb/tbm_unit_tb_top.sv
module tbm_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready, busy, out_valid;
  logic [2:0]  op = 3'd0;
  logic [31:0] s1 = '0, s2 = '0, s3 = '0, res;
  int          checks = 0, errors = 0;

  always #5 clk = ~clk;

  tbm_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .op_i(op), .src1_i(s1), .src2_i(s2), .src3_i(s3),
    .busy_o(busy), .out_valid_o(out_valid), .result_o(res)
  );

  function automatic logic [31:0] model(input logic [2:0] o, input logic [31:0] a, b, c);
    logic [63:0] t;
    logic [31:0] x, y;
    int          k;
    k = int'(b[5:0]);
    x = a; y = c;
    if (k >= 32) begin x = c; y = a; k = k - 32; end
    case (o)
      3'd0: return (a & b) | (c & ~b);
      3'd1: return (b != 0) ? a : c;
      3'd2: begin t = {a, a} << b[4:0]; return t[63:32]; end
      3'd3: begin t = {a, a} >> b[4:0]; return t[31:0]; end
      3'd4: begin t = {x, y} << k; return t[63:32]; end
      3'd5: begin t = {y, x} >> k; return t[31:0]; end
      default: return 32'd0;
    endcase
  endfunction

  function automatic string tag(input logic [2:0] o, input logic [31:0] b);
    if (o >= 3'd4 && (b[5:0] == 6'd0 || b[5:0] == 6'd32)) return "R9";
    case (o)
      3'd0: return "R5";
      3'd1: return "R6";
      3'd2, 3'd3: return "R7";
      3'd4, 3'd5: return "R8";
      default: return "R10";
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [2:0] o, input logic [31:0] a, b, c, input bit scramble);
    logic [31:0] exp;
    bit          tern;
    exp  = model(o, a, b, c);
    tern = (o == 3'd0) || (o == 3'd1) || (o == 3'd4) || (o == 3'd5);
    @(negedge clk);
    in_valid = 1'b1; op = o; s1 = a; s2 = b; s3 = c;
    #1;
    check("R1 busy in accept cycle", {31'd0, busy}, 32'd1);
    check("R1 ready before accept", {31'd0, in_ready}, 32'd1);
    @(negedge clk);
    op = o ^ 3'b101;
    if (scramble && tern) s1 = ~a;
    #1;
    check("R2 out_valid second cycle", {31'd0, out_valid}, 32'd1);
    check("R2 ready low second cycle", {31'd0, in_ready}, 32'd0);
    check("R2 busy low second cycle", {31'd0, busy}, 32'd0);
    check(scramble && tern ? "R4 result with src1 changed" : tag(o, b), res, exp);
    @(negedge clk);
    #1;
    check("R3 request in second cycle not taken", {30'd0, out_valid, in_ready}, 32'd1);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] dummy;
    logic [5:0]  amts [5];
    amts = '{6'd0, 6'd31, 6'd32, 6'd33, 6'd63};
    dummy = $urandom(32'd2024);
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1;
    check("R1 reset ready", {31'd0, in_ready}, 32'd1);
    check("R1 reset out_valid", {31'd0, out_valid}, 32'd0);
    check("R1 reset busy", {31'd0, busy}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    check("R1 idle out_valid", {31'd0, out_valid}, 32'd0);

    for (int o = 0; o < 8; o++)
      for (int i = 0; i < 5; i++) begin
        logic [31:0] b;
        b = $urandom & 32'hFFFF_FFC0;
        b[5:0] = amts[i];
        run_op(3'(o), $urandom, b, $urandom, 1'b0);
      end
    run_op(3'd1, 32'hDEAD_BEEF, 32'd0, 32'h1234_5678, 1'b0);
    run_op(3'd1, 32'hDEAD_BEEF, 32'h8000_0000, 32'h1234_5678, 1'b0);
    run_op(3'd0, 32'hFFFF_0000, 32'hF0F0_F0F0, 32'h0F0F_FFFF, 1'b1);
    run_op(3'd5, 32'h8765_4321, 32'd32, 32'hCAFE_F00D, 1'b1);
    run_op(3'd4, 32'h8765_4321, 32'd0, 32'hCAFE_F00D, 1'b1);

    for (int i = 0; i < 400; i++) begin
      logic [2:0]  o;
      logic [31:0] b;
      o = 3'($urandom % 8);
      b = $urandom;
      if ($urandom % 4 == 0) b[5:0] = amts[$urandom % 5];
      if (o == 3'd1 && ($urandom % 3 == 0)) b = '0;
      run_op(o, $urandom, b, $urandom, ($urandom % 2) == 1);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule